// File: doc/BRIEF.md
# Clock-to-Frame Ratio Detector

This block runs on the master clock. It measures how many master-clock cycles lie between successive rising edges of an already synchronized word clock. It snaps that count to one of six supported master-clock-to-frame ratios and reports the result as a small code. A classification takes effect only after it has been seen in several frames in a row. While that holds, a locked flag is raised, so short jitter and glitches cannot disturb downstream clocking.

From the accepted ratio and a three-way oversampling select, the block derives a single-cycle enable for the modulator. The enable pulses at a fixed division of the master clock. Its divider restarts on every word-clock rising edge, so the modulator phase stays tied to the frame. Counts that fit no ratio fall back to the highest ratio. A word clock that stops or runs very slowly cannot wrap the period counter, because the counter saturates.

Top module: `mclk_ratio_detect`

## Requirements
- R1: `ratio_code` encodes 0=128, 1=192, 2=256, 3=384, 4=512 and 5=768 master clocks per frame. Out of reset `ratio_code` is 5 and `locked` is 0.
- R2: The measured period is the number of master-clock cycles between two consecutive rising edges of `wclk_sync`. It matches a ratio when it lies within ±32 cycles of that ratio, bounds included.
- R3: A count that sits at the same distance from two ratios resolves to the smaller one. For example, 160 gives code 0 and 224 gives code 1.
- R4: A count that matches no ratio is classified as code 5.
- R5: A new code is accepted, and `locked` raised, only after 4 consecutive measurements give the same classification. The first differing measurement drops `locked`. `ratio_code` keeps its old value until the new one is accepted.
- R6: Period jitter that stays inside the ±32 window keeps `locked` high and `ratio_code` unchanged.
- R7: The period count saturates at 1024, so any period longer than 1023 cycles reads as 1024 and is classified as code 5, never as a wrapped small value.
- R8: `rate_sel` selects the oversampling factor: 2'b00 gives 128x, 2'b01 gives 64x, 2'b10 gives 32x, and 2'b11 is treated as 128x.
- R9: `mod_en` is high for one cycle every D master-clock cycles. D is floor(ratio / oversampling factor), with a minimum of 1. The divider restarts on each word-clock rising edge, so a frame of exactly k·D cycles carries k pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk_sync | input | 1 | Word clock, already synchronized to `clk` |
| rate_sel | input | 2 | Oversampling select (R8 encoding) |
| ratio_code | output | 3 | Accepted ratio code (R1 encoding) |
| locked | output | 1 | High while the accepted ratio is confirmed |
| mod_en | output | 1 | Modulator clock enable pulse |

## Verification
A word-clock rising edge can land in the same cycle as the terminal count of the modulator divider. In that cycle the pulse must still be emitted and the restart must win. The bench provokes this with frame lengths that are exact multiples of the divider, and judges it by counting `mod_en` pulses across one whole frame against the expected frame length divided by D. The second same-cycle case is lock acceptance changing the divisor while the divider is partway through a count. Ratio switches between table rows provoke it, and the pulse count of the first fully settled frame must already be exact.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
   localparam int NUM_RATIO = 6;
   typedef logic [2:0] ratio_code_t;
   localparam ratio_code_t CODE_FALLBACK = 3'd5;

   // master clocks per frame for each code
   function automatic int ratio_of(input int idx);
      case (idx)
         0:       return 128;
         1:       return 192;
         2:       return 256;
         3:       return 384;
         4:       return 512;
         default: return 768;
      endcase
   endfunction

   // log2 of the oversampling factor selected by rate_sel
   function automatic int osr_shift(input logic [1:0] sel);
      case (sel)
         2'b01:   return 6;
         2'b10:   return 5;
         default: return 7;
      endcase
   endfunction
endpackage

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
   parameter int CNT_W     = 11,
   parameter int SAT_LIMIT = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wclk_sync,
   output logic             rise,
   output logic [CNT_W-1:0] meas_len,
   output logic             meas_vld
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_LIMIT);

   logic             wclk_q;
   logic             seen;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;

   assign rise    = wclk_sync & ~wclk_q;
   assign cnt_nxt = (cnt >= SAT) ? SAT : cnt + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wclk_q   <= 1'b0;
         seen     <= 1'b0;
         cnt      <= '0;
         meas_len <= '0;
         meas_vld <= 1'b0;
      end else begin
         wclk_q   <= wclk_sync;
         meas_vld <= 1'b0;
         if (rise) begin
            cnt  <= '0;
            seen <= 1'b1;
            if (seen) begin
               meas_len <= cnt_nxt;
               meas_vld <= 1'b1;
            end
         end else begin
            cnt <= cnt_nxt;
         end
      end
   end
endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
   import mrd_pkg::*;
#(
   parameter int CNT_W     = 11,
   parameter int SAT_LIMIT = 1024,
   parameter int TOL       = 32
) (
   input  logic [CNT_W-1:0] meas_len,
   output ratio_code_t      cls_code
);
   logic [NUM_RATIO-1:0] hit;

   for (genvar i = 0; i < NUM_RATIO; i++) begin : g_win
      localparam int R_I = ratio_of(i);
      assign hit[i] = ((int'(meas_len) + TOL) >= R_I) && (int'(meas_len) <= (R_I + TOL));
   end

   // lowest matching ratio wins; no match or saturated count -> fallback
   always_comb begin
      cls_code = CODE_FALLBACK;
      for (int i = NUM_RATIO - 1; i >= 0; i--) begin
         if (hit[i]) cls_code = ratio_code_t'(i);
      end
      if (int'(meas_len) >= SAT_LIMIT) cls_code = CODE_FALLBACK;
   end
endmodule

// File: rtl/mrd_lock_filter.sv
module mrd_lock_filter
   import mrd_pkg::*;
#(
   parameter int LOCK_N = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        meas_vld,
   input  ratio_code_t cls_code,
   output ratio_code_t ratio_code,
   output logic        locked
);
   localparam int RW = $clog2(LOCK_N + 1);
   localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_N);

   ratio_code_t cand;
   logic [RW-1:0] run;
   logic [RW-1:0] run_nxt;

   assign run_nxt = (run >= RUN_MAX) ? run : run + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand       <= CODE_FALLBACK;
         run        <= '0;
         ratio_code <= CODE_FALLBACK;
         locked     <= 1'b0;
      end else if (meas_vld) begin
         if (cls_code != cand) begin
            cand   <= cls_code;
            run    <= RW'(1);
            locked <= 1'b0;
         end else begin
            run <= run_nxt;
            if ((run_nxt == RUN_MAX) && (run != RUN_MAX)) begin
               ratio_code <= cand;
               locked     <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/mrd_mod_enable.sv
module mrd_mod_enable
   import mrd_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rise,
   input  ratio_code_t ratio_code,
   input  logic [1:0]  rate_sel,
   output logic        mod_en
);
   logic [CNT_W-1:0] dcnt;
   logic [CNT_W-1:0] div_m1;
   int               div_i;

   always_comb begin
      div_i = ratio_of(int'(ratio_code)) >> osr_shift(rate_sel);
      if (div_i < 1) div_i = 1;
      div_m1 = CNT_W'(div_i - 1);
   end

   // >= also covers a divisor that shrank while counting
   assign mod_en = (dcnt >= div_m1);

   always_ff @(posedge clk) begin
      if (!rst_n)      dcnt <= '0;
      else if (rise)   dcnt <= '0;
      else if (mod_en) dcnt <= '0;
      else             dcnt <= dcnt + 1'b1;
   end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
   import mrd_pkg::*;
#(
   parameter int CNT_W     = 11,
   parameter int SAT_LIMIT = 1024,
   parameter int TOL       = 32,
   parameter int LOCK_N    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wclk_sync,
   input  logic [1:0] rate_sel,
   output logic [2:0] ratio_code,
   output logic       locked,
   output logic       mod_en
);
   initial begin
      assert (SAT_LIMIT < (1 << CNT_W)) else $error("CNT_W too narrow for SAT_LIMIT");
      assert (SAT_LIMIT > ratio_of(NUM_RATIO - 1) + TOL) else $error("SAT_LIMIT inside a ratio window");
      assert (LOCK_N >= 2) else $error("LOCK_N must be at least 2");
      assert (TOL >= 0 && TOL < 64) else $error("TOL out of range");
   end

   logic             rise;
   logic [CNT_W-1:0] meas_len;
   logic             meas_vld;
   ratio_code_t      cls_code;
   ratio_code_t      code_q;

   mrd_period_counter #(.CNT_W(CNT_W), .SAT_LIMIT(SAT_LIMIT)) i_cnt (
      .clk(clk), .rst_n(rst_n), .wclk_sync(wclk_sync),
      .rise(rise), .meas_len(meas_len), .meas_vld(meas_vld));

   mrd_classifier #(.CNT_W(CNT_W), .SAT_LIMIT(SAT_LIMIT), .TOL(TOL)) i_cls (
      .meas_len(meas_len), .cls_code(cls_code));

   mrd_lock_filter #(.LOCK_N(LOCK_N)) i_lock (
      .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .cls_code(cls_code),
      .ratio_code(code_q), .locked(locked));

   mrd_mod_enable #(.CNT_W(CNT_W)) i_men (
      .clk(clk), .rst_n(rst_n), .rise(rise), .ratio_code(code_q),
      .rate_sel(rate_sel), .mod_en(mod_en));

   assign ratio_code = code_q;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
   parameter int CNT_W     = 11,
   parameter int SAT_LIMIT = 1024,
   parameter int LOCK_N    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       ratio_code,
   input logic             locked,
   input logic             meas_vld,
   input logic [CNT_W-1:0] meas_len
);
   logic [7:0] since;
   logic       locked_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since    <= '0;
         locked_d <= 1'b0;
      end else begin
         locked_d <= locked;
         if (locked_d && !locked)                 since <= '0;
         else if (meas_vld && since < 8'd200)     since <= since + 1'b1;
      end
   end

   AST_CODE_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_code <= 3'd5); // R1
   AST_CODE_HELD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked)) |-> $stable(ratio_code)); // R6
   AST_LOCK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> (int'(since) >= LOCK_N - 1)); // R5
   AST_PERIOD_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      meas_vld |-> (int'(meas_len) <= SAT_LIMIT)); // R7
endmodule

bind mclk_ratio_detect mrd_checker #(.CNT_W(CNT_W), .SAT_LIMIT(SAT_LIMIT), .LOCK_N(LOCK_N)) i_chk (
   .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .locked(locked),
   .meas_vld(meas_vld), .meas_len(meas_len));

// File: tb/test_mclk_ratio_detect.sv
`timescale 1ns/1ps
module test_mclk_ratio_detect;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wclk_sync = 1'b0;
   logic [1:0] rate_sel = 2'b00;
   logic [2:0] ratio_code;
   logic       locked;
   logic       mod_en;

   int n_cmp = 0;
   int n_bad = 0;
   int last_pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mclk_ratio_detect i_mclk_ratio_detect (
      .clk(clk), .rst_n(rst_n), .wclk_sync(wclk_sync), .rate_sel(rate_sel),
      .ratio_code(ratio_code), .locked(locked), .mod_en(mod_en));

   // {period, rate_sel, expected code, expected pulses per frame (-1 = skip)}
   localparam int NV = 15;
   localparam int VEC [0:NV-1][0:3] = '{
      '{256, 0, 2, 128}, '{384, 0, 3, 128}, '{512, 0, 4, 128}, '{768, 0, 5, 128},
      '{128, 1, 0,  64}, '{192, 1, 1,  64}, '{256, 2, 2,  32}, '{288, 0, 2, 144},
      '{289, 0, 5,  -1}, '{160, 1, 0,  80}, '{224, 0, 1, 224}, '{256, 3, 2, 128},
      '{ 96, 0, 0,  96}, '{792, 0, 5, 132}, '{800, 0, 5,  -1}};

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one word-clock frame of n cycles, starting at a negedge
   task automatic frame(input int n);
      int pc = 0;
      wclk_sync = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         pc += int'(mod_en);
         if (i == n / 2 - 1) wclk_sync = 1'b0;
      end
      last_pulses = pc;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset code", int'(ratio_code), 5);
      chk("R1 reset locked", int'(locked), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 R3 R4 R8 R9
      for (int v = 0; v < NV; v++) begin
         rate_sel = 2'(VEC[v][1]);
         repeat (6) frame(VEC[v][0]);
         chk($sformatf("R2/R3/R4 code for period %0d", VEC[v][0]), int'(ratio_code), VEC[v][2]);
         chk($sformatf("R5 locked for period %0d", VEC[v][0]), int'(locked), 1);
         if (VEC[v][3] >= 0)
            chk($sformatf("R8/R9 pulses period %0d sel %0d", VEC[v][0], VEC[v][1]),
                last_pulses, VEC[v][3]);
      end

      // R5: acceptance needs 4 matching measurements
      rate_sel = 2'b00;
      repeat (6) frame(256);
      chk("R5 base lock code", int'(ratio_code), 2);
      repeat (2) frame(512);
      chk("R5 locked dropped", int'(locked), 0);
      chk("R5 code held", int'(ratio_code), 2);
      repeat (2) frame(512);
      chk("R5 still unlocked after 3", int'(locked), 0);
      frame(512);
      chk("R5 locked after 4", int'(locked), 1);
      chk("R5 new code", int'(ratio_code), 4);

      // R6: jitter inside window
      repeat (6) frame(256);
      for (int j = 0; j < 8; j++) begin
         case (j % 4)
            0: frame(258);
            1: frame(253);
            2: frame(261);
            default: frame(255);
         endcase
         chk("R6 jitter locked", int'(locked), 1);
         chk("R6 jitter code", int'(ratio_code), 2);
      end

      // R7: long period saturates instead of wrapping to 256
      repeat (6) frame(2304);
      chk("R7 saturated code", int'(ratio_code), 5);
      chk("R7 saturated locked", int'(locked), 1);
      repeat (6) frame(256);
      chk("R7 recovery code", int'(ratio_code), 2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule